// File: doc/BRIEF.md
# Banked Processor Register File

This block stores the sixteen general registers of a 32-bit processor core: eight data registers and eight address registers. The last address register does not have a single storage cell. It is banked across three physical stack pointers, for user, interrupt and master, and the core's supervisor and master mode bits decide which one answers. Three combinational read ports are provided: two operand ports and an index port. Each can address any of the sixteen registers. One synchronous write port merges byte, word or long-word data into the selected register.

Decode logic drives the register numbers, a two-bit size code and the write data. It also feeds the current supervisor and master bits from the status register. The block registers these two bits internally, so a change in privilege state re-maps the banked register one clock later. A separate load port lets boot logic seed the interrupt stack pointer after reset, whatever the current mode.

Top module: `bank_regfile`

## Requirements
- R1: While reset is asserted (rst_n low), every register and all three stack pointers clear to zero. After reset, every read returns zero until something is written.
- R2: A register number picks the register. Numbers 0 to 7 are data registers D0 to D7, 8 to 14 are address registers A0 to A6, and 15 is the banked stack pointer A7.
- R3: A byte write (size 00) to a data register replaces bits 7:0 only. A word write (size 01) to a data register replaces bits 15:0 only. A long write (size 10) replaces all 32 bits. The untouched bits keep their old value.
- R4: A word write to an address register stores bit 15 of the data copied into bits 31:16. A long write to an address register stores the data unchanged.
- R5: A byte write to an address register has no effect. Size code 11 has no effect on any register.
- R6: Register 15 resolves to the user stack pointer when the registered supervisor bit is 0. It resolves to the interrupt stack pointer when supervisor is 1 and master is 0, and to the master stack pointer when both are 1. A write to register 15 leaves the other two stack pointers unchanged.
- R7: The supervisor and master inputs are sampled at the clock edge. A change on them re-maps register 15 for reads and writes from the cycle after that edge.
- R8: A write lands at the clock edge. A read of the same register in the write cycle returns the old value, and the new value appears in the next cycle.
- R9: The index port returns the same value as an operand port for every register number 0 to 15.
- R10: The interrupt-stack-pointer load port writes its data into the interrupt stack pointer at the clock edge in any mode. In the same cycle it takes priority over a normal write that targets the interrupt stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_mode | input | 1 | Supervisor bit from the status register |
| m_mode | input | 1 | Master/interrupt bit from the status register |
| rd_a_sel | input | 4 | Register number for operand port A |
| rd_a_data | output | 32 | Operand port A data |
| rd_b_sel | input | 4 | Register number for operand port B |
| rd_b_data | output | 32 | Operand port B data |
| idx_sel | input | 4 | Register number for the index port |
| idx_data | output | 32 | Index port data |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Register number to write |
| wr_size | input | 2 | 00 byte, 01 word, 10 long, 11 no write |
| wr_data | input | 32 | Write data, right-aligned |
| isp_init_en | input | 1 | Load strobe for the interrupt stack pointer |
| isp_init_data | input | 32 | Interrupt stack pointer load value |

## Verification
The bench builds the block with its default parameters: XLEN of 32, eight registers per half, and sign extension for address-word writes. With these values the four-bit register number covers the full sixteen-entry space. The banked number 15 and the boundary between data and address registers at 8 can therefore both be reached. Random traffic changes the mode bits often enough that the one-cycle re-mapping lag and the three stack pointer banks are hit many times. Directed cases pin down the merge patterns of byte and word writes, the ignored writes, and the priority of the interrupt stack pointer load.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_NONE = 2'b11
   } rf_size_e;

   localparam int NUM_SP  = 3;
   localparam int SP_USER = 0;
   localparam int SP_INTR = 1;
   localparam int SP_MSTR = 2;
endpackage

// File: rtl/rf_bank_sel.sv
module rf_bank_sel (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s_mode,
   input  logic       m_mode,
   output logic [2:0] bank_oh
);
   import rf_pkg::*;

   logic s_q, m_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q <= 1'b0;
         m_q <= 1'b0;
      end else begin
         s_q <= s_mode;
         m_q <= m_mode;
      end
   end

   always_comb begin
      bank_oh = '0;
      if (!s_q)     bank_oh[SP_USER] = 1'b1;
      else if (m_q) bank_oh[SP_MSTR] = 1'b1;
      else          bank_oh[SP_INTR] = 1'b1;
   end

   // R6: exactly one stack pointer is selected at any time
   p_bank_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_oh) == 1);

   // R7: the bank follows the mode bits sampled one edge earlier
   p_mode_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bank_oh[SP_USER] == !$past(s_mode))
               && (bank_oh[SP_MSTR] == ($past(s_mode) && $past(m_mode))));
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge #(
   parameter int XLEN           = 32,
   parameter bit ADDR_WORD_SEXT = 1'b1
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] wdata,
   input  logic [1:0]      size,
   input  logic            is_addr,
   output logic [XLEN-1:0] new_val,
   output logic            ok
);
   import rf_pkg::*;

   logic [XLEN-1:0] addr_word;

   generate
      if (ADDR_WORD_SEXT) begin : g_sext
         assign addr_word = {{(XLEN-16){wdata[15]}}, wdata[15:0]};
      end else begin : g_zext
         assign addr_word = {{(XLEN-16){1'b0}}, wdata[15:0]};
      end
   endgenerate

   always_comb begin
      new_val = old_val;
      ok      = 1'b0;
      unique case (rf_size_e'(size))
         SZ_BYTE: begin
            ok      = !is_addr;
            new_val = {old_val[XLEN-1:8], wdata[7:0]};
         end
         SZ_WORD: begin
            ok      = 1'b1;
            new_val = is_addr ? addr_word : {old_val[XLEN-1:16], wdata[15:0]};
         end
         SZ_LONG: begin
            ok      = 1'b1;
            new_val = wdata;
         end
         default: begin
            ok      = 1'b0;
            new_val = old_val;
         end
      endcase
   end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
   parameter int XLEN  = 32,
   parameter int NGEN  = 15,
   parameter int SEL_W = 4
) (
   input  logic [NGEN-1:0][XLEN-1:0] gen_q,
   input  logic [2:0][XLEN-1:0]      sp_q,
   input  logic [2:0]                bank_oh,
   input  logic [SEL_W-1:0]          sel,
   output logic [XLEN-1:0]           data
);
   localparam logic [SEL_W-1:0] SP_SEL = SEL_W'(NGEN);

   logic [XLEN-1:0] sp_val;

   always_comb begin
      sp_val = '0;
      for (int k = 0; k < 3; k++)
         sp_val |= sp_q[k] & {XLEN{bank_oh[k]}};
   end

   always_comb begin
      if (sel == SP_SEL) data = sp_val;
      else               data = gen_q[sel];
   end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
   parameter int XLEN           = 32,
   parameter int HALF           = 8,
   parameter bit ADDR_WORD_SEXT = 1'b1,
   localparam int NREG          = 2 * HALF,
   localparam int SEL_W         = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_mode,
   input  logic             m_mode,
   input  logic [SEL_W-1:0] rd_a_sel,
   output logic [XLEN-1:0]  rd_a_data,
   input  logic [SEL_W-1:0] rd_b_sel,
   output logic [XLEN-1:0]  rd_b_data,
   input  logic [SEL_W-1:0] idx_sel,
   output logic [XLEN-1:0]  idx_data,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [1:0]       wr_size,
   input  logic [XLEN-1:0]  wr_data,
   input  logic             isp_init_en,
   input  logic [XLEN-1:0]  isp_init_data
);
   import rf_pkg::*;

   localparam int NGEN = NREG - 1;
   localparam int NRD  = 4;
   localparam logic [SEL_W-1:0] SP_SEL = SEL_W'(NREG - 1);

   generate
      if (XLEN < 16 || (XLEN % 8) != 0) begin : g_bad_xlen
         $error("XLEN must be a multiple of 8 and at least 16");
      end
      if (HALF < 2 || (HALF & (HALF - 1)) != 0) begin : g_bad_half
         $error("HALF must be a power of two of at least 2");
      end
   endgenerate

   logic [NGEN-1:0][XLEN-1:0]  gen_q;
   logic [NUM_SP-1:0][XLEN-1:0] sp_q;
   logic [2:0]                 bank_oh;

   rf_bank_sel u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_mode  (s_mode),
      .m_mode  (m_mode),
      .bank_oh (bank_oh)
   );

   logic [NRD-1:0][SEL_W-1:0] rsel;
   logic [NRD-1:0][XLEN-1:0]  rdata;

   assign rsel[0] = rd_a_sel;
   assign rsel[1] = rd_b_sel;
   assign rsel[2] = idx_sel;
   assign rsel[3] = wr_sel;

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_rd
         rf_read_port #(.XLEN(XLEN), .NGEN(NGEN), .SEL_W(SEL_W)) u_rd (
            .gen_q   (gen_q),
            .sp_q    (sp_q),
            .bank_oh (bank_oh),
            .sel     (rsel[p]),
            .data    (rdata[p])
         );
      end
   endgenerate

   assign rd_a_data = rdata[0];
   assign rd_b_data = rdata[1];
   assign idx_data  = rdata[2];

   logic [XLEN-1:0] wval;
   logic            wok;

   rf_write_merge #(.XLEN(XLEN), .ADDR_WORD_SEXT(ADDR_WORD_SEXT)) u_merge (
      .old_val (rdata[3]),
      .wdata   (wr_data),
      .size    (wr_size),
      .is_addr (wr_sel[SEL_W-1]),
      .new_val (wval),
      .ok      (wok)
   );

   logic wr_go;
   assign wr_go = wr_en && wok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_q <= '0;
         sp_q  <= '0;
      end else begin
         for (int i = 0; i < NGEN; i++)
            if (wr_go && wr_sel == SEL_W'(i)) gen_q[i] <= wval;
         for (int k = 0; k < NUM_SP; k++) begin
            if (k == SP_INTR && isp_init_en)
               sp_q[k] <= isp_init_data;
            else if (wr_go && wr_sel == SP_SEL && bank_oh[k])
               sp_q[k] <= wval;
         end
      end
   end

   // R1: reset clears all storage
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (gen_q == '0) && (sp_q == '0));

   // R3: a byte write to a data register keeps its upper bits
   p_byte_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_sel[SEL_W-1] && wr_size == 2'b00
      |=> gen_q[$past(wr_sel)][XLEN-1:8] == $past(gen_q[wr_sel][XLEN-1:8]));

   // R4: a word write to an address register fills the upper bits from bit 15
   p_addr_word_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sel[SEL_W-1] && wr_sel != SP_SEL && wr_size == 2'b01
      |=> gen_q[$past(wr_sel)][XLEN-1:16] == {(XLEN-16){$past(wr_data[15])}});

   // R5: ignored writes leave every register untouched
   p_ignored_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !isp_init_en && (!wr_en || wr_size == 2'b11 || (wr_sel[SEL_W-1] && wr_size == 2'b00))
      |=> $stable(gen_q) && $stable(sp_q));

   // R6: a stack pointer write in user state leaves the other two alone
   p_sp_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bank_oh[SP_USER] && !isp_init_en
      |=> $stable(sp_q[SP_INTR]) && $stable(sp_q[SP_MSTR]));

   // R10: the load port always wins for the interrupt stack pointer
   p_isp_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      isp_init_en |=> sp_q[SP_INTR] == $past(isp_init_data));
endmodule

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_mode = 1'b0, m_mode = 1'b0;
   logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, idx_sel = '0, wr_sel = '0;
   logic [31:0] rd_a_data, rd_b_data, idx_data;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_size = 2'b10;
   logic [31:0] wr_data = '0;
   logic        isp_init_en = 1'b0;
   logic [31:0] isp_init_data = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   bank_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .s_mode(s_mode), .m_mode(m_mode),
      .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
      .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
      .idx_sel(idx_sel), .idx_data(idx_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
      .isp_init_en(isp_init_en), .isp_init_data(isp_init_data)
   );

   // reference model state
   logic [31:0] mreg [15];
   logic [31:0] msp  [3];
   logic        ms_q, mm_q;

   function automatic int bank_of(input logic s, input logic m);
      if (!s) return 0;
      return m ? 2 : 1;
   endfunction

   function automatic logic [31:0] mread(input logic [3:0] sel);
      if (sel == 4'd15) return msp[bank_of(ms_q, mm_q)];
      return mreg[sel];
   endfunction

   function automatic logic wr_allowed(input logic [3:0] sel, input logic [1:0] sz);
      if (sz == 2'b11) return 1'b0;
      if (sel[3] && sz == 2'b00) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [31:0] merged(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] sel, input logic [1:0] sz);
      if (sz == 2'b10) return d;
      if (sz == 2'b00) return {old[31:8], d[7:0]};
      if (sel[3]) return {{16{d[15]}}, d[15:0]};
      return {old[31:16], d[15:0]};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] sel, input logic [1:0] sz, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_size = sz; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] sel, input logic [31:0] exp, input string tag);
      rd_a_sel = sel;
      #1;
      chk(rd_a_data, exp, tag);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0; isp_init_en = 1'b0; s_mode = 1'b0; m_mode = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      for (int i = 0; i < 15; i++) mreg[i] = '0;
      for (int k = 0; k < 3; k++) msp[k] = '0;
      ms_q = 1'b0; mm_q = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1 reset state, R9 index port across all numbers
      for (int i = 0; i < 16; i++) begin
         idx_sel = 4'(i);
         #1;
         chk(idx_data, 32'h0, "R1 reset value via index R9");
      end
      s_mode = 1'b1; m_mode = 1'b0; tick();
      rd_chk(4'd15, 32'h0, "R1 interrupt sp after reset");
      m_mode = 1'b1; tick();
      rd_chk(4'd15, 32'h0, "R1 master sp after reset");
      s_mode = 1'b0; m_mode = 1'b0; tick();

      // R3 data register merges
      wr(4'd2, 2'b10, 32'h11223344);
      rd_chk(4'd2, 32'h11223344, "R3 long write data reg");
      wr(4'd2, 2'b00, 32'hFFFFFFAB);
      rd_chk(4'd2, 32'h112233AB, "R3 byte write data reg");
      wr(4'd2, 2'b01, 32'hFFFFCDEF);
      rd_chk(4'd2, 32'h1122CDEF, "R3 word write data reg");

      // R4 address register word sign extension, R2 numbering
      wr(4'd11, 2'b01, 32'h00008001);
      rd_chk(4'd11, 32'hFFFF8001, "R4 word write addr reg negative");
      rd_chk(4'd3, 32'h0, "R2 D3 untouched by A3 write");
      wr(4'd11, 2'b01, 32'hFFFF7FFF);
      rd_chk(4'd11, 32'h00007FFF, "R4 word write addr reg positive");
      wr(4'd11, 2'b10, 32'hDEADBEEF);
      rd_chk(4'd11, 32'hDEADBEEF, "R4 long write addr reg");

      // R5 ignored writes
      wr(4'd11, 2'b00, 32'h00000055);
      rd_chk(4'd11, 32'hDEADBEEF, "R5 byte write to addr reg ignored");
      wr(4'd2, 2'b11, 32'h99999999);
      rd_chk(4'd2, 32'h1122CDEF, "R5 size 11 ignored");

      // R6 banked stack pointer
      wr(4'd15, 2'b10, 32'h00001000);
      s_mode = 1'b1; m_mode = 1'b0; tick();
      wr(4'd15, 2'b10, 32'h00002000);
      m_mode = 1'b1; tick();
      wr(4'd15, 2'b10, 32'h00003000);
      rd_chk(4'd15, 32'h00003000, "R6 master sp");
      m_mode = 1'b0; tick();
      rd_chk(4'd15, 32'h00002000, "R6 interrupt sp");
      s_mode = 1'b0; tick();
      rd_chk(4'd15, 32'h00001000, "R6 user sp");

      // R7 mode change lags by one edge
      s_mode = 1'b1; m_mode = 1'b1;
      rd_chk(4'd15, 32'h00001000, "R7 before edge still user sp");
      tick();
      rd_chk(4'd15, 32'h00003000, "R7 after edge master sp");

      // R8 same-cycle read returns old value
      rd_a_sel = 4'd5; wr_en = 1'b1; wr_sel = 4'd5; wr_size = 2'b10; wr_data = 32'hA5A5A5A5;
      #1;
      chk(rd_a_data, 32'h0, "R8 read during write is old");
      tick(); wr_en = 1'b0;
      rd_chk(4'd5, 32'hA5A5A5A5, "R8 read after write is new");

      // R10 interrupt sp load
      s_mode = 1'b0; m_mode = 1'b0;
      isp_init_en = 1'b1; isp_init_data = 32'h00004444;
      tick(); isp_init_en = 1'b0;
      s_mode = 1'b1; tick();
      rd_chk(4'd15, 32'h00004444, "R10 load in user mode");
      isp_init_en = 1'b1; isp_init_data = 32'h00005555;
      wr(4'd15, 2'b10, 32'h00009999);
      isp_init_en = 1'b0;
      rd_chk(4'd15, 32'h00005555, "R10 load beats normal write");

      // random phase against model
      do_reset();
      void'($urandom(32'd1234));
      for (int c = 0; c < 3000; c++) begin
         logic [3:0] ws;
         logic [1:0] wz;
         logic [31:0] wd;
         logic [31:0] nv;
         int b;
         rd_a_sel = 4'($urandom);
         rd_b_sel = 4'($urandom);
         idx_sel  = (c % 16 == 0) ? 4'd15 : 4'($urandom);
         ws = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom);
         wz = 2'($urandom);
         wd = $urandom;
         wr_en = ($urandom % 3) != 0;
         wr_sel = ws; wr_size = wz; wr_data = wd;
         isp_init_en = ($urandom % 16) == 0;
         isp_init_data = $urandom;
         if ($urandom % 5 == 0) begin
            s_mode = 1'($urandom);
            m_mode = 1'($urandom);
         end
         #1;
         chk(rd_a_data, mread(rd_a_sel), "R2 R8 random port A");
         chk(rd_b_data, mread(rd_b_sel), "R6 R7 random port B");
         chk(idx_data,  mread(idx_sel),  "R9 random index port");
         b = bank_of(ms_q, mm_q);
         nv = merged(mread(ws), wd, ws, wz);
         @(posedge clk);
         if (wr_en && wr_allowed(ws, wz)) begin
            if (ws == 4'd15) msp[b] = nv;
            else mreg[ws] = nv;
         end
         if (isp_init_en) msp[1] = isp_init_data;
         ms_q = s_mode; mm_q = m_mode;
         @(negedge clk);
      end
      wr_en = 1'b0; isp_init_en = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule